// File: doc/BRIEF.md
# Serial ADC read controller

This block sits on the host side of a 3-wire serial successive-approximation converter with a 12-bit result. It owns the active-low chip select and the serial clock, samples the converter's serial data line, and hands each result to the rest of the chip on a valid/ready output. Alongside the data it returns a flag that says whether the word is a genuine sample, and a flag that reports a bad leading bit.

Every read is a 16-clock frame. The converter samples when chip select falls and sends one leading zero, then the twelve result bits with the MSB first, then zeros. There is no pipeline delay, so a frame returns the sample taken at its own start. A power-down command starts a frame and cuts it short inside the allowed clock window. A convert command that arrives while the converter is powered down first runs a dummy frame and throws its data away. An explicit wake command runs only the dummy frame and reports its word as not valid. The serial clock rate is set per command by a divider value. Between frames, chip select stays high for a minimum quiet time.

Top module: `sadc_rdctl`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0, res_valid is 0, pwr_down is 0 and cmd_ready is 1.
- R2: cmd_op encodes the commands as 0 = convert, 1 = power-down, 2 = wake and 3 = reserved. A command is taken only when cmd_valid and cmd_ready are both high. cmd_ready is high only while the block is idle and no result is waiting. The reserved code, and any command offered while cmd_ready is low, starts no frame and leaves pwr_down unchanged.
- R3: A convert frame holds cs_n low for exactly 16 sclk periods. sclk is low whenever cs_n is high, and cs_n rises after the 16th sclk falling edge.
- R4: Data is captured on sclk rising edges. The 1st captured bit is the leading bit, and the 2nd to 13th captured bits become res_data[11] down to res_data[0]. Later bits are ignored.
- R5: res_frame_err is 1 when the leading bit of the delivered frame was 1, and 0 when it was 0.
- R6: Every sclk half-period lasts clk_div+1 system clocks, with clk_div taken when the command is accepted. The same spacing applies from the cs_n fall to the first rising edge, and from the last falling edge to the cs_n rise.
- R7: Between two frames, cs_n stays high for at least QUIET_CYC (default 3) system clocks.
- R8: A power-down command, given while the converter is awake, runs a frame whose cs_n rises after the PD_EDGE-th (default 4) falling edge. That count lies between 2 and 9. The frame delivers no result and sets pwr_down. A power-down command given while pwr_down is 1 is ignored.
- R9: A convert command given while pwr_down is 1 first runs a full 16-clock dummy frame and discards it. It then runs a conversion whose result is delivered with res_sample_ok = 1, and pwr_down ends at 0.
- R10: A wake command given while pwr_down is 1 runs one 16-clock dummy frame and delivers its word with res_sample_ok = 0, which clears pwr_down. A wake command given while pwr_down is 0 is ignored.
- R11: A delivered result keeps res_valid, res_data, res_sample_ok and res_frame_err stable until res_ready is seen high.
- R12: busy is 1 from the cs_n falling edge until the quiet time after the frame has expired, and it is 1 whenever cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | sclk half-period in system clocks, minus one |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 2 | Command code (0 convert, 1 power-down, 2 wake) |
| cmd_ready | output | 1 | Command can be taken this cycle |
| busy | output | 1 | Frame or quiet time in progress |
| pwr_down | output | 1 | Converter is in power-down |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock, idles low |
| adc_sdata | input | 1 | Converter serial data |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken |
| res_data | output | DATA_W | 12-bit result |
| res_sample_ok | output | 1 | Result is a genuine sample |
| res_frame_err | output | 1 | Leading bit of the frame was nonzero |

## Verification
The assertions assume the following about the inputs:
- reset is applied before the first command;
- adc_sdata changes only in response to sclk falling edges or chip select edges, so it is settled at every rising edge the controller samples;
- res_ready and the command inputs change only away from the active clock edge.

The bench meets these conditions as follows:
- it drives the data line from a converter model that reacts only to those pin edges;
- it drives every input on the falling edge of the system clock;
- it stays inside the documented command encoding, except for one deliberate use of the reserved code.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [1:0] {
    OP_CONV  = 2'd0,
    OP_PDOWN = 2'd1,
    OP_WAKE  = 2'd2,
    OP_RSVD  = 2'd3
  } sadc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_QUIET = 2'd2
  } sadc_st_e;

  typedef enum logic [1:0] {
    FK_CONV  = 2'd0,
    FK_PDOWN = 2'd1,
    FK_DUMMY = 2'd2,
    FK_WAKE  = 2'd3
  } sadc_kind_e;

endpackage

// File: rtl/sadc_clkdiv.sv
module sadc_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_m1,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == half_m1);
    cnt_d = cnt_q;
    if (!en || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= half_m1)); // R6

endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              din,
  output logic              lead_bit,
  output logic [DATA_W-1:0] field
);

  localparam int SH_W = DATA_W + 1;

  logic [SH_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (clr) begin
      sh_d = '0;
    end else if (shift_en) begin
      sh_d = {sh_q[SH_W-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign lead_bit = sh_q[SH_W-1];
  assign field    = sh_q[DATA_W-1:0];

  AST_CLR_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && shift_en)); // R4

endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int DATA_W     = 12,
  parameter int FRAME_CLKS = 16,
  parameter int PD_EDGE    = 4,
  parameter int QUIET_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              cmd_ready,
  output logic              busy,
  output logic              pwr_down,
  output logic              cs_n,
  output logic              sclk,
  output logic              div_en,
  output logic [DIV_W-1:0]  div_val,
  input  logic              tick,
  output logic              cap_clr,
  output logic              cap_en,
  input  logic              lead_bit,
  input  logic [DATA_W-1:0] field,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_ok,
  output logic              res_err
);

  localparam int CNT_W = $clog2(FRAME_CLKS + 1);
  localparam int QW    = $clog2(QUIET_CYC + 1);
  localparam logic [CNT_W-1:0] FULL_N  = CNT_W'(FRAME_CLKS);
  localparam logic [CNT_W-1:0] ABORT_N = CNT_W'(PD_EDGE);
  localparam logic [CNT_W-1:0] CAP_N   = CNT_W'(DATA_W + 1);
  localparam logic [QW-1:0]    Q_LAST  = QW'(QUIET_CYC - 1);

  sadc_st_e         st_q, st_d;
  sadc_kind_e       kind_q, kind_d;
  logic             cs_q, cs_d;
  logic             sclk_q, sclk_d;
  logic [CNT_W-1:0] fall_q, fall_d;
  logic [QW-1:0]    qcnt_q, qcnt_d;
  logic             chain_q, chain_d;
  logic             pd_q, pd_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             rv_q, rv_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic             rok_q, rok_d;
  logic             rerr_q, rerr_d;

  logic             accept, start, in_frame, at_end;
  logic [CNT_W-1:0] end_n;
  sadc_op_e         op;

  always_comb begin
    op        = sadc_op_e'(cmd_op);
    in_frame  = (st_q == ST_FRAME);
    cmd_ready = (st_q == ST_IDLE) && !rv_q;
    accept    = cmd_valid && cmd_ready;
    end_n     = (kind_q == FK_PDOWN) ? ABORT_N : FULL_N;
    at_end    = in_frame && tick && !sclk_q && (fall_q == end_n);
    cap_en    = in_frame && tick && !sclk_q && (fall_q != end_n) && (fall_q < CAP_N);
    div_en    = in_frame;
  end

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    cs_d    = cs_q;
    sclk_d  = sclk_q;
    fall_d  = fall_q;
    qcnt_d  = qcnt_q;
    chain_d = chain_q;
    pd_d    = pd_q;
    div_d   = div_q;
    rv_d    = rv_q;
    rd_d    = rd_q;
    rok_d   = rok_q;
    rerr_d  = rerr_q;
    start   = 1'b0;

    if (rv_q && res_ready) begin
      rv_d = 1'b0;
    end

    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          div_d = clk_div;
          unique case (op)
            OP_CONV: begin
              start   = 1'b1;
              kind_d  = pd_q ? FK_DUMMY : FK_CONV;
              chain_d = pd_q;
            end
            OP_PDOWN: begin
              if (!pd_q) begin
                start  = 1'b1;
                kind_d = FK_PDOWN;
              end
            end
            OP_WAKE: begin
              if (pd_q) begin
                start  = 1'b1;
                kind_d = FK_WAKE;
              end
            end
            default: ;
          endcase
        end
      end
      ST_FRAME: begin
        if (tick) begin
          if (sclk_q) begin
            sclk_d = 1'b0;
            fall_d = fall_q + 1'b1;
          end else if (at_end) begin
            cs_d   = 1'b1;
            st_d   = ST_QUIET;
            qcnt_d = '0;
            unique case (kind_q)
              FK_CONV: begin
                rv_d   = 1'b1;
                rd_d   = field;
                rok_d  = 1'b1;
                rerr_d = lead_bit;
              end
              FK_WAKE: begin
                rv_d   = 1'b1;
                rd_d   = field;
                rok_d  = 1'b0;
                rerr_d = lead_bit;
                pd_d   = 1'b0;
              end
              FK_DUMMY: pd_d = 1'b0;
              FK_PDOWN: pd_d = 1'b1;
              default: ;
            endcase
          end else begin
            sclk_d = 1'b1;
          end
        end
      end
      ST_QUIET: begin
        if (qcnt_q == Q_LAST) begin
          if (chain_q) begin
            start   = 1'b1;
            kind_d  = FK_CONV;
            chain_d = 1'b0;
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          qcnt_d = qcnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (start) begin
      st_d   = ST_FRAME;
      cs_d   = 1'b0;
      sclk_d = 1'b0;
      fall_d = '0;
    end
    cap_clr = start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= FK_CONV;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      fall_q  <= '0;
      qcnt_q  <= '0;
      chain_q <= 1'b0;
      pd_q    <= 1'b0;
      div_q   <= '0;
      rv_q    <= 1'b0;
      rd_q    <= '0;
      rok_q   <= 1'b0;
      rerr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      kind_q  <= kind_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      fall_q  <= fall_d;
      qcnt_q  <= qcnt_d;
      chain_q <= chain_d;
      pd_q    <= pd_d;
      div_q   <= div_d;
      rv_q    <= rv_d;
      rd_q    <= rd_d;
      rok_q   <= rok_d;
      rerr_q  <= rerr_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign pwr_down  = pd_q;
  assign cs_n      = cs_q;
  assign sclk      = sclk_q;
  assign div_val   = div_q;
  assign res_valid = rv_q;
  assign res_data  = rd_q;
  assign res_ok    = rok_q;
  assign res_err   = rerr_q;

  AST_CS_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> busy); // R12
  AST_SCLK_LOW_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk_q); // R3
  AST_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_q) && kind_q != FK_PDOWN) |-> (fall_q == FULL_N)); // R3
  AST_PD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_q) && kind_q == FK_PDOWN) |-> (fall_q >= CNT_W'(2) && fall_q < CNT_W'(10))); // R8
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !res_ready) |=> (rv_q && $stable(rd_q) && $stable(rok_q) && $stable(rerr_q))); // R11
  AST_NO_CMD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready); // R2
  AST_QUIET_BEFORE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_q) && $past(st_q) == ST_QUIET) |-> ($past(qcnt_q) == Q_LAST)); // R7

endmodule

// File: rtl/sadc_rdctl.sv
module sadc_rdctl #(
  parameter int DIV_W      = 8,
  parameter int DATA_W     = 12,
  parameter int FRAME_CLKS = 16,
  parameter int PD_EDGE    = 4,
  parameter int QUIET_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  output logic              cmd_ready,
  output logic              busy,
  output logic              pwr_down,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  input  logic              adc_sdata,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic              res_sample_ok,
  output logic              res_frame_err
);

  logic              div_en, tick, cap_clr, cap_en, lead_bit;
  logic [DIV_W-1:0]  div_val;
  logic [DATA_W-1:0] field;

  sadc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (div_en),
    .half_m1 (div_val),
    .tick    (tick)
  );

  sadc_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cap_clr),
    .shift_en (cap_en),
    .din      (adc_sdata),
    .lead_bit (lead_bit),
    .field    (field)
  );

  sadc_ctrl #(
    .DIV_W      (DIV_W),
    .DATA_W     (DATA_W),
    .FRAME_CLKS (FRAME_CLKS),
    .PD_EDGE    (PD_EDGE),
    .QUIET_CYC  (QUIET_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .clk_div   (clk_div),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .pwr_down  (pwr_down),
    .cs_n      (adc_cs_n),
    .sclk      (adc_sclk),
    .div_en    (div_en),
    .div_val   (div_val),
    .tick      (tick),
    .cap_clr   (cap_clr),
    .cap_en    (cap_en),
    .lead_bit  (lead_bit),
    .field     (field),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_ok    (res_sample_ok),
    .res_err   (res_frame_err)
  );

endmodule

// File: tb/sadc_rdctl_tb.sv
module sadc_rdctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int QUIET      = 3;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  clk_div;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic        cmd_ready, busy, pwr_down, adc_cs_n, adc_sclk;
  logic        adc_sdata;
  logic        res_valid, res_ready, res_sample_ok, res_frame_err;
  logic [11:0] res_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadc_rdctl #(.QUIET_CYC(QUIET)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_ready(cmd_ready), .busy(busy), .pwr_down(pwr_down),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdata(adc_sdata),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_sample_ok(res_sample_ok), .res_frame_err(res_frame_err)
  );

  // Converter model: samples on chip select fall, shifts after sclk falls.
  logic [11:0] m_sample = 12'h000;
  bit          m_bad = 1'b0;
  bit          m_pd = 1'b0;
  bit          m_dummy = 1'b0;
  bit          m_cs_prev = 1'b1;
  logic [15:0] m_word = 16'h0000;
  int          m_pos = 0;
  int          m_falls = 0;
  int          m_frames = 0;
  int          m_last_falls = 0;

  initial adc_sdata = 1'b0;

  always @(negedge adc_cs_n or posedge adc_cs_n or negedge adc_sclk) begin
    if (adc_cs_n !== m_cs_prev) begin
      m_cs_prev = adc_cs_n;
      if (adc_cs_n === 1'b0) begin
        m_dummy = m_pd;
        m_word  = m_pd ? 16'hFFFF : {m_bad, m_sample, 3'b000};
        m_pos   = 0;
        m_falls = 0;
        adc_sdata = m_word[15];
      end else begin
        m_frames++;
        m_last_falls = m_falls;
        if (m_falls >= 2 && m_falls < 10) m_pd = 1'b1;
        else if (m_falls >= 10 && m_dummy) m_pd = 1'b0;
        adc_sdata = 1'b0;
      end
    end else if (adc_cs_n === 1'b0) begin
      m_pos++;
      m_falls++;
      adc_sdata = (m_pos < 16) ? m_word[4'(15 - m_pos)] : 1'b0;
    end
  end

  // Pin-timing monitor, sampled on the falling system clock edge.
  int  cur_div = 0;
  int  since_evt = 0;
  int  since_rise = 1000;
  bit  p_cs = 1'b1;
  bit  p_sclk = 1'b0;
  int  rate_viol = 0;
  int  quiet_viol = 0;
  int  busy_viol = 0;
  int  desel_viol = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      since_evt++;
      since_rise++;
      if (adc_cs_n !== p_cs || adc_sclk !== p_sclk) begin
        if (p_cs == 1'b0 && since_evt != cur_div + 1) rate_viol++;
        if (p_cs == 1'b1 && adc_cs_n == 1'b0 && since_rise < QUIET) quiet_viol++;
        if (p_cs == 1'b0 && adc_cs_n == 1'b1) since_rise = 0;
        since_evt = 0;
      end
      if (!adc_cs_n && !busy) busy_viol++;
      if (adc_cs_n && adc_sclk) desel_viol++;
      p_cs   = adc_cs_n;
      p_sclk = adc_sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WD_CYCLES, 0);
    finish_run();
  end

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  div;
    logic [11:0] sample;
    logic        bad;
    logic        exp_res;
    logic        exp_ok;
    logic [1:0]  exp_frames;
    logic        exp_pd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd0, 12'hA5C, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0}, // R4 convert
    '{2'd0, 8'd3, 12'h123, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0}, // R5 bad lead
    '{2'd1, 8'd1, 12'h000, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1}, // R8 power-down
    '{2'd1, 8'd1, 12'h000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1}, // R8 repeat ignored
    '{2'd0, 8'd2, 12'h7FF, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0}, // R9 wake via convert
    '{2'd1, 8'd0, 12'h000, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1}, // R8
    '{2'd2, 8'd0, 12'h000, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0}, // R10 explicit wake
    '{2'd2, 8'd0, 12'h000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R10 wake ignored
    '{2'd0, 8'd0, 12'hFFF, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0}, // R4
    '{2'd3, 8'd0, 12'h000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R2 reserved
    '{2'd0, 8'd5, 12'h000, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0}  // R6 slow clock
  };

  task automatic wait_ready();
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] div);
    wait_ready();
    cur_div   = int'(div);
    clk_div   = div;
    cmd_op    = op;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic pop_result();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid == 1'b0, "R11", "res_valid after pop", int'(res_valid), 0);
  endtask

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_op    = 2'd0;
    clk_div   = 8'd0;
    res_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(adc_cs_n == 1'b1, "R1", "cs_n in reset", int'(adc_cs_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(adc_cs_n == 1'b1 && adc_sclk == 1'b0, "R1", "cs_n/sclk idle",
        int'({adc_cs_n, adc_sclk}), 2);
    chk(busy == 1'b0 && res_valid == 1'b0 && pwr_down == 1'b0, "R1",
        "busy/res_valid/pwr_down", int'({busy, res_valid, pwr_down}), 0);
    chk(cmd_ready == 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);

    for (int i = 0; i < NV; i++) begin
      int f0;
      f0 = m_frames;
      m_sample = VECS[i].sample;
      m_bad    = VECS[i].bad;
      issue(VECS[i].op, VECS[i].div);
      chk(m_frames - f0 == int'(VECS[i].exp_frames), "R2", "frames per command",
          m_frames - f0, int'(VECS[i].exp_frames));
      if (VECS[i].exp_frames != 0) begin
        // R3 full frames, R8 aborted power-down frame
        chk(m_last_falls == ((VECS[i].op == 2'd1) ? 4 : 16),
            (VECS[i].op == 2'd1) ? "R8" : "R3", "falling edges in frame",
            m_last_falls, (VECS[i].op == 2'd1) ? 4 : 16);
      end
      chk(pwr_down == VECS[i].exp_pd, "R8", "pwr_down after command",
          int'(pwr_down), int'(VECS[i].exp_pd));
      chk(res_valid == VECS[i].exp_res, "R9", "result delivered",
          int'(res_valid), int'(VECS[i].exp_res));
      if (VECS[i].exp_res) begin
        chk(res_sample_ok == VECS[i].exp_ok, "R10", "sample ok flag",
            int'(res_sample_ok), int'(VECS[i].exp_ok));
        if (VECS[i].exp_ok) begin
          chk(res_data == VECS[i].sample, "R4", "res_data",
              int'(res_data), int'(VECS[i].sample));
          chk(res_frame_err == VECS[i].bad, "R5", "frame error flag",
              int'(res_frame_err), int'(VECS[i].bad));
        end
      end
      if (res_valid) pop_result();
    end

    // R11: result held while not taken, commands refused meanwhile (R2)
    begin
      int f0;
      m_sample = 12'h5A3;
      m_bad    = 1'b0;
      issue(2'd0, 8'd1);
      repeat (30) @(negedge clk);
      chk(res_valid == 1'b1 && res_data == 12'h5A3, "R11", "held result",
          int'(res_data), 12'h5A3);
      chk(cmd_ready == 1'b0, "R11", "cmd_ready while pending", int'(cmd_ready), 0);
      f0 = m_frames;
      cmd_op = 2'd1;
      cmd_valid = 1'b1;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
      pop_result();
      repeat (4) @(negedge clk);
      chk(m_frames == f0 && pwr_down == 1'b0, "R2", "command while pending ignored",
          m_frames - f0, 0);
    end

    // R2/R12: command offered mid-frame is ignored
    begin
      int f0;
      f0 = m_frames;
      m_sample = 12'h0F0;
      wait_ready();
      cur_div = 7;
      clk_div = 8'd7;
      cmd_op = 2'd0;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_op = 2'd1;
      repeat (5) @(negedge clk);
      chk(busy == 1'b1 && adc_cs_n == 1'b0, "R12", "busy during frame",
          int'(busy), 1);
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
      while (busy) @(negedge clk);
      chk(m_frames - f0 == 1 && pwr_down == 1'b0, "R2", "mid-frame command ignored",
          m_frames - f0, 1);
      chk(res_data == 12'h0F0, "R4", "res_data slow frame", int'(res_data), 12'h0F0);
      pop_result();
    end

    chk(rate_viol == 0, "R6", "sclk half-period violations", rate_viol, 0);
    chk(quiet_viol == 0, "R7", "quiet time violations", quiet_viol, 0);
    chk(busy_viol == 0, "R12", "cs low without busy", busy_viol, 0);
    chk(desel_viol == 0, "R3", "sclk high while deselected", desel_viol, 0);
    finish_run();
  end

endmodule